// File: doc/BRIEF.md
# Serial/Parallel Register with J/K-bar Serial Entry

A small bank of edge-triggered flip-flops that either captures a parallel word or shifts its contents one place per rising clock edge, depending on one mode input. In shift mode, each stage takes the value held by the stage below it. The entry stage does not take a plain data bit. Instead it is steered by a J input and an active-low K input. This lets the entry stage clear, set, toggle or hold itself while the rest of the chain advances. Wiring J and K-bar together turns the entry into an ordinary D-type serial input.

An active-low clear acts without the clock. It zeroes every stage at once and keeps them at zero for as long as it is held low, whatever the clock and mode inputs do. The outputs are every stage in parallel plus an inverted copy of the final stage. Stage 0 is the entry stage and stage WIDTH-1 is the final stage.

Top module: `jk_shift_register`

## Requirements
- R1: With `shift_en` low, the rising clock edge copies `par_d[i]` into `q[i]` for every stage i.
- R2: With `shift_en` low, the values of `j_in` and `kb_in` have no effect: after the edge, `q` equals `par_d` exactly.
- R3: With `shift_en` high, the rising edge moves `q[i-1]` into `q[i]` for every i from 1 to WIDTH-1.
- R4: During a shift, `q[0]` becomes 0 when {`j_in`,`kb_in`} = 2'b00 and becomes 1 when it is 2'b11.
- R5: During a shift, `q[0]` inverts when {`j_in`,`kb_in`} = 2'b10 and keeps its value when it is 2'b01.
- R6: With `j_in` and `kb_in` driven to the same value, a shift loads that value into `q[0]`, so the entry acts as a D input.
- R7: Driving `clr_n` low forces `q` to all zeros without waiting for a clock edge.
- R8: While `clr_n` is low, rising clock edges leave `q` at all zeros in both modes.
- R9: `q_last_n` always equals the inverse of `q[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | 1 = shift toward the final stage, 0 = parallel load |
| par_d | input | WIDTH | Parallel data, bit i feeds stage i |
| j_in | input | 1 | J steering input of the entry stage |
| kb_in | input | 1 | Active-low K steering input of the entry stage |
| q | output | WIDTH | Stage outputs, bit 0 is the entry stage |
| q_last_n | output | 1 | Inverted final-stage output |

## Verification
The bench builds the register with the default WIDTH of 4. At that width all sixteen parallel words can be loaded one after another. A bit entered at stage 0 reaches the final stage and the inverted output after three shifts, so a toggle pattern walks through the whole chain within a few cycles. Random runs mix loads, shifts in all four J/K-bar combinations, and clears that start half-way through a cycle and hold across an edge, so the asynchronous path and the no-clock-effect path are both reached.

// File: rtl/regshf_pkg.sv
package regshf_pkg;

    // Operating mode selected by the shift/load control.
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_SHIFT = 1'b1
    } op_e;

    // Entry stage action, encoded as {j, kb}.
    typedef enum logic [1:0] {
        ENTRY_CLEAR  = 2'b00,
        ENTRY_HOLD   = 2'b01,
        ENTRY_TOGGLE = 2'b10,
        ENTRY_SET    = 2'b11
    } entry_e;

    typedef struct packed {
        op_e    op;
        entry_e entry;
    } ctrl_t;

    function automatic entry_e decode_entry(input logic j, input logic kb);
        return entry_e'({j, kb});
    endfunction

    function automatic logic entry_next(input entry_e act, input logic cur);
        logic r;
        case (act)
            ENTRY_CLEAR:  r = 1'b0;
            ENTRY_HOLD:   r = cur;
            ENTRY_TOGGLE: r = ~cur;
            default:      r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/regshf_entry.sv
module regshf_entry
    import regshf_pkg::*;
(
    input  logic   cur,
    input  entry_e act,
    output logic   nxt
);
    always_comb begin
        nxt = entry_next(act, cur);
    end
endmodule

// File: rtl/regshf_next.sv
module regshf_next
    import regshf_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    input  logic             entry_bit,
    output logic [WIDTH-1:0] nxt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic shift_src;
        if (i == 0) begin : g_first
            assign shift_src = entry_bit;
        end else begin : g_rest
            assign shift_src = cur[i-1];
        end
        assign nxt[i] = (op == OP_SHIFT) ? shift_src : load_val[i];
    end
endmodule

// File: rtl/jk_shift_register.sv
module jk_shift_register
    import regshf_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] par_d,
    input  logic             j_in,
    input  logic             kb_in,
    output logic [WIDTH-1:0] q,
    output logic             q_last_n
);
    localparam int LAST = WIDTH - 1;

    ctrl_t            ctrl;
    logic             entry_bit;
    logic [WIDTH-1:0] q_nxt;

    always_comb begin
        ctrl.op    = shift_en ? OP_SHIFT : OP_LOAD;
        ctrl.entry = decode_entry(j_in, kb_in);
    end

    regshf_entry u_entry (
        .cur (q[0]),
        .act (ctrl.entry),
        .nxt (entry_bit)
    );

    regshf_next #(.WIDTH(WIDTH)) u_next (
        .op        (ctrl.op),
        .cur       (q),
        .load_val  (par_d),
        .entry_bit (entry_bit),
        .nxt       (q_nxt)
    );

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

    assign q_last_n = ~q[LAST];

    // Register checks
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        !shift_en |=> q == $past(par_d)); // R1
    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (!clr_n)
        shift_en |=> q[LAST:1] == $past(q[LAST-1:0])); // R3
    AST_ENTRY_SET: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && j_in && kb_in) |=> q[0]); // R4
    AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && !j_in && !kb_in) |=> !q[0]); // R4
    AST_ENTRY_TOGGLE: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && j_in && !kb_in) |=> q[0] != $past(q[0])); // R5
    AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && !j_in && kb_in) |=> $stable(q[0])); // R5
    AST_CLEAR_HELD: assert property (@(posedge clk)
        !clr_n |-> q == '0); // R8

endmodule

// File: tb/jk_shift_register_bench.sv
module jk_shift_register_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         shift_en = 1'b0;
    logic [W-1:0] par_d = '0;
    logic         j_in = 1'b0;
    logic         kb_in = 1'b0;
    logic [W-1:0] q;
    logic         q_last_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0] val;
        string        req;
    } exp_t;

    exp_t         sbq[$];
    logic [W-1:0] model = '0;

    always #4 clk = ~clk;

    jk_shift_register #(.WIDTH(W)) u_jk_shift_register (
        .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .par_d(par_d),
        .j_in(j_in), .kb_in(kb_in), .q(q), .q_last_n(q_last_n)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic ref_entry(input logic cur, input logic j, input logic kb);
        if (j && kb) return 1'b1;
        if (!j && !kb) return 1'b0;
        if (j) return ~cur;
        return cur;
    endfunction

    // Driver: applies one cycle of stimulus mid-cycle and queues the expectation.
    task automatic drive(input logic c, input logic s, input logic [W-1:0] d,
                         input logic j, input logic kb, input string req);
        @(negedge clk);
        clr_n = c; shift_en = s; par_d = d; j_in = j; kb_in = kb;
        if (!c) begin
            model = '0;
            #1;
            check(q, '0, "R7 async clear");
        end else if (!s) begin
            model = d;
        end else begin
            model = {model[W-2:0], ref_entry(model[0], j, kb)};
        end
        sbq.push_back('{val: model, req: req});
    endtask

    // Monitor: compares the design with the queued expectation after each edge.
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(q, e.val, e.req);
            check({{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, ~e.val[W-1]}, "R9 inverted last");
        end
    end

    initial begin
        #1 clr_n = 1'b0;
        #1 check(q, '0, "R7 reset state");
        drive(0, 0, 4'b1111, 1, 1, "R8 clear held");
        drive(0, 1, 4'b0110, 1, 1, "R8 clear held");
        // Loads with serial inputs wiggling
        drive(1, 0, 4'b1010, 1, 0, "R1 R2 load");
        drive(1, 0, 4'b0101, 0, 0, "R2 load ignores j/kb");
        drive(1, 0, 4'b0011, 1, 1, "R2 load ignores j/kb");
        // Entry stage modes during shift
        drive(1, 1, 4'b0000, 1, 1, "R3 R4 set");
        drive(1, 1, 4'b1111, 0, 0, "R3 R4 clear");
        drive(1, 1, 4'b0000, 1, 0, "R3 R5 toggle");
        drive(1, 1, 4'b0000, 1, 0, "R3 R5 toggle");
        drive(1, 1, 4'b1111, 0, 1, "R3 R5 hold");
        drive(1, 1, 4'b1111, 0, 1, "R3 R5 hold");
        // D-type use
        drive(1, 1, 4'b0000, 1, 1, "R6 d-entry");
        drive(1, 1, 4'b0000, 0, 0, "R6 d-entry");
        drive(1, 1, 4'b0000, 1, 1, "R6 d-entry");
        drive(1, 1, 4'b0000, 1, 1, "R6 d-entry");
        // Clear mid-cycle and held over edges
        drive(1, 0, 4'b1111, 0, 0, "R1 load");
        drive(0, 1, 4'b1111, 1, 1, "R7 R8 clear mid-cycle");
        drive(0, 0, 4'b1010, 0, 0, "R8 edge ignored");
        drive(1, 0, 4'b1001, 0, 0, "R1 load after clear");
        // Every load word
        for (int v = 0; v < (1 << W); v++) begin
            drive(1, 0, v[W-1:0], v[0], v[1], "R1 R2 exhaustive load");
        end
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic c, s, j, kb;
            logic [W-1:0] d;
            c = ($urandom % 12) != 0;
            s = $urandom % 2;
            j = $urandom % 2;
            kb = $urandom % 2;
            d = W'($urandom);
            drive(c, s, d, j, kb, !c ? "R8 random" : (!s ? "R1 random" : "R3 random"));
        end
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule